// File: doc/BRIEF.md
# Fused Multiply-Add NaN Operand Selector

This block decides which NaN a three-operand fused multiply-add `(a*b)+c` returns when one or more of its operands is a NaN. An upstream classifier supplies one quiet flag and one signaling flag for each operand, plus an indicator that the product is infinity times zero. The block returns a two-bit code that tells the result mux to forward operand a, b or c, or to build the default NaN. It also raises an invalid-operation flag.

The block is purely combinational, so its outputs follow its inputs in the same cycle. A build-time parameter selects one of four priority policies. In the mode-switched policy, a run-time input swaps between two search orders. Classifying the operands and muxing the values are done outside this block.

Top module: `fma_nan_select`

## Requirements
- R1: `selCode` encodes the pick as 0 = operand a, 1 = operand b, 2 = operand c and 3 = default NaN. Bit 0 of `quietNan` and `signalNan` belongs to a, bit 1 to b and bit 2 to c.
- R2: Under every policy, `invalidOp` is 1 whenever any bit of `signalNan` is 1.
- R3: Addend-first policy (POLICY = POL_ADDEND_FIRST): when `infTimesZero` is 1 and c is a quiet NaN, `selCode` is 3 and `invalidOp` is 1.
- R4: Addend-first policy, otherwise: the pick is the first match in this list: c signaling, a signaling, b signaling, c quiet, a quiet. If none matches, the pick is b.
- R5: Addend-first policy: when `infTimesZero` is 1 but c is not a quiet NaN, the selection follows R4, and `invalidOp` is raised only by R2.
- R6: Mode-switched policy (POL_MODE_SWITCH): `infTimesZero` = 1 forces `selCode` = 3 and `invalidOp` = 1, whatever the flags.
- R7: Mode-switched policy with `snanBitInverted` = 1: the search takes signaling NaNs in the order a, b, c, then quiet NaNs in the order a, b. If none matches, the pick is c.
- R8: Mode-switched policy with `snanBitInverted` = 0: the search takes signaling NaNs in the order c, a, b, then quiet NaNs in the order c, a. If none matches, the pick is b.
- R9: Multiplicand-first policy (POL_A_THEN_C): `infTimesZero` = 1 gives `invalidOp` = 1 and `selCode` = 2.
- R10: Multiplicand-first policy, otherwise: a is picked if it is any NaN, then c if it is any NaN, and b otherwise. Quiet and signaling NaNs are treated alike.
- R11: Plain policy (POL_PLAIN): a is preferred over b, and b over c, for any kind of NaN. `infTimesZero` has no effect on either output.
- R12: `snanBitInverted` has no effect on either output under any policy other than mode-switched.
- R13: Both outputs settle in the same cycle as the inputs; there is no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| quietNan | input | 3 | Quiet-NaN flag for each operand (bit 0 a, bit 1 b, bit 2 c) |
| signalNan | input | 3 | Signaling-NaN flag for each operand (same bit order) |
| infTimesZero | input | 1 | The product term is infinity times zero |
| snanBitInverted | input | 1 | Run-time order switch used by the mode-switched policy |
| selCode | output | 2 | Selected source: 0 a, 1 b, 2 c, 3 default NaN |
| invalidOp | output | 1 | Invalid-operation exception flag |

## Verification
Both results are combinational, so each one is due in the same cycle as the stimulus that produces it. The bench drives a new input set just after a rising clock edge and samples both outputs at the following falling edge. That half period leaves the logic time to settle, and no read races the drive. One instance per policy sees the same stimulus, and each result is compared against a reference model written directly from the requirement list. Every legal flag combination is swept, and directed scenarios cover the forced-code cases and the effect of the mode input.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;

  localparam int NUM_OPS  = 3;
  localparam int IDX_W    = 2;

  typedef logic [IDX_W-1:0] opIdx_t;

  localparam opIdx_t OP_A        = 2'd0;
  localparam opIdx_t OP_B        = 2'd1;
  localparam opIdx_t OP_C        = 2'd2;
  localparam opIdx_t OP_DEFAULT  = 2'd3;

  typedef enum logic [1:0] {
    POL_ADDEND_FIRST = 2'd0,
    POL_MODE_SWITCH  = 2'd1,
    POL_A_THEN_C     = 2'd2,
    POL_PLAIN        = 2'd3
  } policy_e;

  // Control-to-datapath strobes
  typedef struct packed {
    opIdx_t [NUM_OPS-1:0] order;       // order[0] searched first
    logic                 splitKinds;  // signaling pass before quiet pass
    logic                 forceCode;   // override the search result
    opIdx_t               forcedVal;
    logic                 raiseInvalid;
  } nanStrobe_t;

endpackage

// File: rtl/fma_nan_ctrl.sv
module fma_nan_ctrl
  import fma_nan_pkg::*;
#(
  parameter policy_e POLICY = POL_ADDEND_FIRST
) (
  input  logic               cQuiet,
  input  logic               infTimesZero,
  input  logic               snanBitInverted,
  output nanStrobe_t         strobes
);

  always_comb begin
    strobes = '0;
    case (POLICY)
      POL_ADDEND_FIRST: begin
        strobes.splitKinds = 1'b1;
        strobes.order[0]   = OP_C;
        strobes.order[1]   = OP_A;
        strobes.order[2]   = OP_B;
        if (infTimesZero && cQuiet) begin
          strobes.forceCode    = 1'b1;
          strobes.forcedVal    = OP_DEFAULT;
          strobes.raiseInvalid = 1'b1;
        end
      end
      POL_MODE_SWITCH: begin
        strobes.splitKinds = 1'b1;
        if (snanBitInverted) begin
          strobes.order[0] = OP_A;
          strobes.order[1] = OP_B;
          strobes.order[2] = OP_C;
        end else begin
          strobes.order[0] = OP_C;
          strobes.order[1] = OP_A;
          strobes.order[2] = OP_B;
        end
        if (infTimesZero) begin
          strobes.forceCode    = 1'b1;
          strobes.forcedVal    = OP_DEFAULT;
          strobes.raiseInvalid = 1'b1;
        end
      end
      POL_A_THEN_C: begin
        strobes.splitKinds = 1'b0;
        strobes.order[0]   = OP_A;
        strobes.order[1]   = OP_C;
        strobes.order[2]   = OP_B;
        if (infTimesZero) begin
          strobes.forceCode    = 1'b1;
          strobes.forcedVal    = OP_C;
          strobes.raiseInvalid = 1'b1;
        end
      end
      default: begin
        strobes.splitKinds = 1'b0;
        strobes.order[0]   = OP_A;
        strobes.order[1]   = OP_B;
        strobes.order[2]   = OP_C;
      end
    endcase
  end

endmodule

// File: rtl/fma_nan_datapath.sv
module fma_nan_datapath
  import fma_nan_pkg::*;
(
  input  logic [NUM_OPS-1:0] quietNan,
  input  logic [NUM_OPS-1:0] signalNan,
  input  nanStrobe_t         strobes,
  output opIdx_t             selCode,
  output logic               invalidOp
);

  logic [NUM_OPS-1:0] firstMask;
  logic [NUM_OPS-1:0] secondMask;
  logic [NUM_OPS-1:0] hitFirst;
  logic [NUM_OPS-1:0] hitSecond;
  opIdx_t             pick;

  assign firstMask  = strobes.splitKinds ? signalNan : (signalNan | quietNan);
  assign secondMask = strobes.splitKinds ? quietNan  : '0;

  // Per-slot hit flags along the search order
  for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_slot
    assign hitFirst[gi]  = firstMask[strobes.order[gi]];
    assign hitSecond[gi] = secondMask[strobes.order[gi]];
  end

  always_comb begin
    logic found;
    found = 1'b0;
    pick  = strobes.order[NUM_OPS-1];
    for (int i = 0; i < NUM_OPS; i++) begin
      if (!found && hitFirst[i]) begin
        pick  = strobes.order[i];
        found = 1'b1;
      end
    end
    for (int i = 0; i < NUM_OPS; i++) begin
      if (!found && hitSecond[i]) begin
        pick  = strobes.order[i];
        found = 1'b1;
      end
    end
  end

  assign selCode   = strobes.forceCode ? strobes.forcedVal : pick;
  assign invalidOp = strobes.raiseInvalid | (|signalNan);

  // Signaling NaNs win over quiet ones when the search splits kinds (R4, R7, R8)
  always_comb begin
    if (strobes.splitKinds && !strobes.forceCode && (|signalNan) && selCode != OP_DEFAULT)
      a_r4_signal_before_quiet: assert (signalNan[selCode])
        else $error("signaling NaN not preferred");
  end

endmodule

// File: rtl/fma_nan_select.sv
module fma_nan_select
  import fma_nan_pkg::*;
#(
  parameter policy_e POLICY = POL_ADDEND_FIRST
) (
  input  logic [2:0] quietNan,
  input  logic [2:0] signalNan,
  input  logic       infTimesZero,
  input  logic       snanBitInverted,
  output logic [1:0] selCode,
  output logic       invalidOp
);

  nanStrobe_t strobes;

  fma_nan_ctrl #(.POLICY(POLICY)) u_ctrl (
    .cQuiet          (quietNan[OP_C]),
    .infTimesZero    (infTimesZero),
    .snanBitInverted (snanBitInverted),
    .strobes         (strobes)
  );

  fma_nan_datapath u_dp (
    .quietNan  (quietNan),
    .signalNan (signalNan),
    .strobes   (strobes),
    .selCode   (selCode),
    .invalidOp (invalidOp)
  );

  always_comb begin
    if (|signalNan)
      a_r2_snan_invalid: assert (invalidOp) else $error("R2 invalid missing");
    if (POLICY == POL_ADDEND_FIRST && infTimesZero && quietNan[2])
      a_r3_default_on_iz: assert (selCode == 2'd3 && invalidOp) else $error("R3");
    if (POLICY == POL_MODE_SWITCH && infTimesZero)
      a_r6_mode_iz: assert (selCode == 2'd3 && invalidOp) else $error("R6");
    if (POLICY == POL_A_THEN_C && infTimesZero)
      a_r9_addend_on_iz: assert (selCode == 2'd2 && invalidOp) else $error("R9");
    if (POLICY == POL_A_THEN_C && !infTimesZero && (quietNan[0] | signalNan[0]))
      a_r10_a_first: assert (selCode == 2'd0) else $error("R10");
    if (POLICY == POL_PLAIN)
      a_r11_never_default: assert (selCode != 2'd3) else $error("R11");
  end

endmodule

// File: tb/fma_nan_select_tb.sv
module fma_nan_select_tb;
  import fma_nan_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0] quietNan;
  logic [2:0] signalNan;
  logic       infTimesZero;
  logic       snanBitInverted;
  logic [1:0] selAdd, selMode, selAc, selPlain;
  logic       invAdd, invMode, invAc, invPlain;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  fma_nan_select #(.POLICY(POL_ADDEND_FIRST)) u_dut (
    .quietNan(quietNan), .signalNan(signalNan), .infTimesZero(infTimesZero),
    .snanBitInverted(snanBitInverted), .selCode(selAdd), .invalidOp(invAdd));
  fma_nan_select #(.POLICY(POL_MODE_SWITCH)) u_dutMode (
    .quietNan(quietNan), .signalNan(signalNan), .infTimesZero(infTimesZero),
    .snanBitInverted(snanBitInverted), .selCode(selMode), .invalidOp(invMode));
  fma_nan_select #(.POLICY(POL_A_THEN_C)) u_dutAc (
    .quietNan(quietNan), .signalNan(signalNan), .infTimesZero(infTimesZero),
    .snanBitInverted(snanBitInverted), .selCode(selAc), .invalidOp(invAc));
  fma_nan_select #(.POLICY(POL_PLAIN)) u_dutPlain (
    .quietNan(quietNan), .signalNan(signalNan), .infTimesZero(infTimesZero),
    .snanBitInverted(snanBitInverted), .selCode(selPlain), .invalidOp(invPlain));

  // Reference model written from the requirement list: {invalid, code}
  function automatic logic [2:0] refModel(int pol, logic [2:0] q, logic [2:0] s,
                                          logic iz, logic m);
    logic inv;
    logic [1:0] code;
    inv = |s;
    if (pol == 0) begin
      if (iz && q[2]) begin inv = 1; code = 3; end
      else if (s[2]) code = 2; else if (s[0]) code = 0; else if (s[1]) code = 1;
      else if (q[2]) code = 2; else if (q[0]) code = 0; else code = 1;
    end else if (pol == 1) begin
      if (iz) begin inv = 1; code = 3; end
      else if (m) begin
        if (s[0]) code = 0; else if (s[1]) code = 1; else if (s[2]) code = 2;
        else if (q[0]) code = 0; else if (q[1]) code = 1; else code = 2;
      end else begin
        if (s[2]) code = 2; else if (s[0]) code = 0; else if (s[1]) code = 1;
        else if (q[2]) code = 2; else if (q[0]) code = 0; else code = 1;
      end
    end else if (pol == 2) begin
      if (iz) begin inv = 1; code = 2; end
      else if (q[0] | s[0]) code = 0;
      else if (q[2] | s[2]) code = 2;
      else code = 1;
    end else begin
      if (q[0] | s[0]) code = 0; else if (q[1] | s[1]) code = 1; else code = 2;
    end
    return {inv, code};
  endfunction

  task automatic drive(logic [2:0] q, logic [2:0] s, logic iz, logic m);
    @(posedge clk);
    quietNan = q; signalNan = s; infTimesZero = iz; snanBitInverted = m;
    @(negedge clk);
  endtask

  task automatic expect3(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s q=%b s=%b iz=%b m=%b actual={inv,code}=%b expected=%b",
               req, quietNan, signalNan, infTimesZero, snanBitInverted, act, exp);
    end
  endtask

  // R1/R13: all-clear input, outputs valid in the same cycle
  task automatic t_idle();
    drive(3'b000, 3'b000, 0, 0);
    expect3("R1 R13 addend idle", {invAdd, selAdd}, 3'b001);
    expect3("R1 R13 mode idle",   {invMode, selMode}, 3'b001);
    expect3("R1 R13 ac idle",     {invAc, selAc}, 3'b001);
    expect3("R1 R13 plain idle",  {invPlain, selPlain}, 3'b010);
  endtask

  task automatic t_addend();
    drive(3'b100, 3'b000, 1, 0);
    expect3("R3 iz with c quiet", {invAdd, selAdd}, 3'b111);
    drive(3'b001, 3'b010, 0, 0);
    expect3("R4 b signaling beats a quiet", {invAdd, selAdd}, 3'b101);
    drive(3'b000, 3'b101, 0, 0);
    expect3("R4 c signaling first", {invAdd, selAdd}, 3'b110);
    drive(3'b001, 3'b000, 1, 0);
    expect3("R5 iz without c quiet", {invAdd, selAdd}, 3'b000);
  endtask

  task automatic t_mode();
    drive(3'b000, 3'b000, 1, 1);
    expect3("R6 iz forces default", {invMode, selMode}, 3'b111);
    drive(3'b001, 3'b110, 0, 1);
    expect3("R7 inverted b signaling", {invMode, selMode}, 3'b101);
    drive(3'b110, 3'b000, 0, 1);
    expect3("R7 inverted b quiet", {invMode, selMode}, 3'b001);
    drive(3'b110, 3'b000, 0, 0);
    expect3("R8 normal c quiet", {invMode, selMode}, 3'b010);
    drive(3'b000, 3'b011, 0, 0);
    expect3("R8 normal a signaling", {invMode, selMode}, 3'b100);
  endtask

  task automatic t_ac();
    drive(3'b001, 3'b000, 1, 0);
    expect3("R9 iz gives c", {invAc, selAc}, 3'b110);
    drive(3'b000, 3'b101, 0, 0);
    expect3("R10 a signaling", {invAc, selAc}, 3'b100);
    drive(3'b100, 3'b010, 0, 0);
    expect3("R10 c quiet over b signaling", {invAc, selAc}, 3'b110);
  endtask

  task automatic t_plain();
    drive(3'b010, 3'b100, 1, 0);
    expect3("R11 b over c, iz ignored", {invPlain, selPlain}, 3'b101);
    drive(3'b000, 3'b000, 1, 1);
    expect3("R11 iz no invalid", {invPlain, selPlain}, 3'b010);
  endtask

  // R12: the mode input toggled on each non-mode policy
  task automatic t_modeIgnored();
    logic [2:0] a0, c0, p0;
    drive(3'b010, 3'b100, 0, 0);
    a0 = {invAdd, selAdd}; c0 = {invAc, selAc}; p0 = {invPlain, selPlain};
    drive(3'b010, 3'b100, 0, 1);
    expect3("R12 addend mode ignored", {invAdd, selAdd}, a0);
    expect3("R12 ac mode ignored", {invAc, selAc}, c0);
    expect3("R12 plain mode ignored", {invPlain, selPlain}, p0);
  endtask

  // R2 and all orders: sweep every legal flag combination
  task automatic t_sweep();
    for (int v = 0; v < 256; v++) begin
      logic [7:0] bits;
      bits = v[7:0];
      if ((bits[2:0] & bits[5:3]) != 3'b000) continue;
      drive(bits[2:0], bits[5:3], bits[6], bits[7]);
      expect3("R2 R4 sweep addend", {invAdd, selAdd},
              refModel(0, bits[2:0], bits[5:3], bits[6], bits[7]));
      expect3("R2 R7 R8 sweep mode", {invMode, selMode},
              refModel(1, bits[2:0], bits[5:3], bits[6], bits[7]));
      expect3("R2 R10 sweep ac", {invAc, selAc},
              refModel(2, bits[2:0], bits[5:3], bits[6], bits[7]));
      expect3("R2 R11 sweep plain", {invPlain, selPlain},
              refModel(3, bits[2:0], bits[5:3], bits[6], bits[7]));
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    quietNan = '0; signalNan = '0; infTimesZero = 0; snanBitInverted = 0;
    t_idle();
    t_addend();
    t_mode();
    t_ac();
    t_plain();
    t_modeIgnored();
    t_sweep();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

endmodule